// File: doc/BRIEF.md
# Data Cache Lock Range Sequencer

This block controls locking for a data cache. Software programs one linear address window with a base register and a size register. It then writes 1 to an enable bit. That write starts a hardware walk over every cache block in the window. The walk issues maintenance commands to the cache one at a time, each completed by an acknowledge:

1. It clears out the cache slots that the window will occupy.
2. It refetches every block of the window.
3. It puts the replacement state of the touched sets back to its initial value.

After the walk, the block raises per-set lock flags. The replacement logic uses these flags to keep those sets' locked contents from ever being chosen as victims.

Writing 0 to the enable issues no commands. It only drops the lock flags, so the blocks become ordinary replacement candidates again. Writing 1 while the enable already reads 1 runs the whole walk again. While a walk is in progress, a busy status bit reads 1 and every register write is discarded. A zero-sized window sets the enable and does nothing else.

Top module: `dlock_ctrl`

## Requirements
- R1: After reset, the enable bit and the busy bit read 0, `lock_mask` is all zero and `cmd_valid` is low.
- R2: Register index 0 holds the base and index 1 holds the size. Each keeps write data bits [15:4] and reads bits [3:0] as zero. Index 2 is control: bit 0 is the enable and bit 1 is the read-only busy bit. All other control bits read 0, and index 3 reads 0.
- R3: Every command address is a 16-byte-aligned block address `a` with base <= a < base + size. No other address is ever presented.
- R4: A walk over N blocks issues exactly 4N commands. First come N slot evictions (op 1) in ascending block order. Next, for each block in ascending order, a line flush (op 2) followed by a fetch (op 3). Last come N replacement-state resets (op 4) in ascending order.
- R5: `cmd_valid` stays high with `cmd_op` and `cmd_addr` unchanged until `cmd_ack` is sampled high. Only one command is outstanding at a time.
- R6: When a walk ends, busy reads 0. `lock_mask` then has bit s set exactly for each set s = address bits [6:4] of some block in the window.
- R7: Writing 1 to the enable while it already reads 1 re-runs the complete command sequence. `lock_mask` reads zero for as long as busy reads 1.
- R8: Writing 0 to the enable while idle issues no command, clears `lock_mask` on the next cycle and makes the enable read 0.
- R9: While busy reads 1, writes to base, size and control are ignored. Their read values and the running walk stay unchanged.
- R10: Writing 1 to the enable with a size of zero sets the enable to 1. It never raises busy or `cmd_valid`, and `lock_mask` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cmd_valid | output | 1 | Maintenance command present |
| cmd_op | output | 3 | Command code: 1 evict slot, 2 flush line, 3 fetch, 4 reset replacement state |
| cmd_addr | output | 16 | Block-aligned command address |
| cmd_ack | input | 1 | Command accepted by the cache |
| lock_mask | output | 8 | Per-set lock flags for victim exclusion |

## Verification
A walker that holds the wrong position or phase shows up on the command port at the very next command. The address drifts outside the window, an opcode lands out of order, or the total count differs from 4N. Staged lock bits that are lost or stale appear in `lock_mask` one cycle after the walk leaves its commit state. A register that fails to stay frozen while busy shows up in the read-back value in the cycle right after the ignored write.

// File: rtl/dlock_pkg.sv
package dlock_pkg;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_EVICT_SLOT = 3'd1,
        OP_FLUSH_LINE = 3'd2,
        OP_FETCH      = 3'd3,
        OP_LRU_INIT   = 3'd4
    } lk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FLUSH,
        ST_FETCH,
        ST_LRU,
        ST_COMMIT
    } lk_st_e;

    localparam logic [1:0] RA_BASE = 2'd0;
    localparam logic [1:0] RA_SIZE = 2'd1;
    localparam logic [1:0] RA_CTRL = 2'd2;

endpackage

// File: rtl/dlock_regs.sv
module dlock_regs
    import dlock_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] size,
    output logic              enable,
    output logic              start,
    output logic              stop
);

    localparam int HI_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] size;
        logic              en;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d     = q;
        start = 1'b0;
        stop  = 1'b0;
        if (reg_wen && !busy) begin
            case (reg_addr)
                RA_BASE: d.base = {reg_wdata[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                RA_SIZE: d.size = {reg_wdata[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                RA_CTRL: begin
                    d.en = reg_wdata[0];
                    if (reg_wdata[0]) begin
                        start = (q.size[ADDR_W-1:OFF_W] != {HI_W{1'b0}});
                    end else begin
                        stop = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_BASE: reg_rdata[ADDR_W-1:0] = q.base;
            RA_SIZE: reg_rdata[ADDR_W-1:0] = q.size;
            RA_CTRL: begin
                reg_rdata[0] = q.en;
                reg_rdata[1] = busy;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign base   = q.base;
    assign size   = q.size;
    assign enable = q.en;

endmodule

// File: rtl/dlock_walker.sv
module dlock_walker
    import dlock_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int SET_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    input  logic              cmd_ack,
    output logic              busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              stage_we,
    output logic [SET_W-1:0]  stage_idx,
    output logic              commit
);

    localparam int               PW  = ADDR_W + 1;
    localparam logic [PW-1:0]    BLK = PW'(1) << OFF_W;

    typedef struct packed {
        lk_st_e        st;
        logic [PW-1:0] cur;
        logic [PW-1:0] first;
        logic [PW-1:0] stop_at;
    } walk_t;

    walk_t q, d;

    logic          accepted;
    logic          last_blk;
    logic [PW-1:0] next_cur;

    always_comb begin
        next_cur = q.cur + BLK;
        last_blk = (next_cur >= q.stop_at);
        accepted = cmd_valid && cmd_ack;
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_NONE;
        case (q.st)
            ST_EVICT: begin cmd_valid = 1'b1; cmd_op = OP_EVICT_SLOT; end
            ST_FLUSH: begin cmd_valid = 1'b1; cmd_op = OP_FLUSH_LINE; end
            ST_FETCH: begin cmd_valid = 1'b1; cmd_op = OP_FETCH;      end
            ST_LRU:   begin cmd_valid = 1'b1; cmd_op = OP_LRU_INIT;   end
            default: ;
        endcase
        cmd_addr  = q.cur[ADDR_W-1:0];
        busy      = (q.st != ST_IDLE);
        stage_we  = (q.st == ST_LRU) && accepted;
        stage_idx = q.cur[OFF_W+SET_W-1:OFF_W];
        commit    = (q.st == ST_COMMIT);
    end

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = ST_EVICT;
                    d.cur     = {1'b0, base};
                    d.first   = {1'b0, base};
                    d.stop_at = {1'b0, base} + {1'b0, size};
                end
            end
            ST_EVICT: begin
                if (accepted) begin
                    if (last_blk) begin
                        d.st  = ST_FLUSH;
                        d.cur = q.first;
                    end else begin
                        d.cur = next_cur;
                    end
                end
            end
            ST_FLUSH: begin
                if (accepted) d.st = ST_FETCH;
            end
            ST_FETCH: begin
                if (accepted) begin
                    if (last_blk) begin
                        d.st  = ST_LRU;
                        d.cur = q.first;
                    end else begin
                        d.st  = ST_FLUSH;
                        d.cur = next_cur;
                    end
                end
            end
            ST_LRU: begin
                if (accepted) begin
                    if (last_blk) d.st  = ST_COMMIT;
                    else          d.cur = next_cur;
                end
            end
            ST_COMMIT: d.st = ST_IDLE;
            default:   d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.cur     <= '0;
            q.first   <= '0;
            q.stop_at <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dlock_flags.sv
module dlock_flags #(
    parameter int SET_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   stage_we,
    input  logic [SET_W-1:0]       stage_idx,
    input  logic                   commit,
    output logic [(1<<SET_W)-1:0]  lock_mask
);

    localparam int NUM_SETS = 1 << SET_W;

    typedef struct packed {
        logic [NUM_SETS-1:0] staged;
        logic [NUM_SETS-1:0] mask;
    } flags_t;

    flags_t q, d;
    logic [NUM_SETS-1:0] hit;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_dec
        assign hit[s] = stage_we && (stage_idx == SET_W'(s));
    end

    always_comb begin
        d = q;
        if (clear) begin
            d.staged = '0;
            d.mask   = '0;
        end else begin
            d.staged = q.staged | hit;
            if (commit) d.mask = q.staged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lock_mask = q.mask;

endmodule

// File: rtl/dlock_ctrl.sv
module dlock_ctrl
    import dlock_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int SET_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wen,
    input  logic [1:0]            reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  cmd_valid,
    output logic [2:0]            cmd_op,
    output logic [ADDR_W-1:0]     cmd_addr,
    input  logic                  cmd_ack,
    output logic [(1<<SET_W)-1:0] lock_mask
);

    logic              busy_w;
    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] size_w;
    logic              enable_w;
    logic              start_w;
    logic              stop_w;
    logic              stage_we_w;
    logic [SET_W-1:0]  stage_idx_w;
    logic              commit_w;

    dlock_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy_w),
        .reg_rdata (reg_rdata),
        .base      (base_w),
        .size      (size_w),
        .enable    (enable_w),
        .start     (start_w),
        .stop      (stop_w)
    );

    dlock_walker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .base      (base_w),
        .size      (size_w),
        .cmd_ack   (cmd_ack),
        .busy      (busy_w),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .stage_we  (stage_we_w),
        .stage_idx (stage_idx_w),
        .commit    (commit_w)
    );

    dlock_flags #(.SET_W(SET_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_w | stop_w),
        .stage_we  (stage_we_w),
        .stage_idx (stage_idx_w),
        .commit    (commit_w),
        .lock_mask (lock_mask)
    );

endmodule

// File: rtl/dlock_chk.sv
module dlock_chk #(
    parameter int ADDR_W = 16,
    parameter int SET_W  = 3,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wen,
    input logic [1:0]            reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic                  cmd_valid,
    input logic [2:0]            cmd_op,
    input logic [ADDR_W-1:0]     cmd_addr,
    input logic                  cmd_ack,
    input logic [(1<<SET_W)-1:0] lock_mask,
    input logic                  busy,
    input logic [ADDR_W-1:0]     base,
    input logic [ADDR_W-1:0]     size
);

    logic [ADDR_W:0] win_end;
    assign win_end = {1'b0, base} + {1'b0, size};

    p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr));

    p_cmd_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ({1'b0, cmd_addr} >= {1'b0, base}) && ({1'b0, cmd_addr} < win_end));

    p_op_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op >= 3'd1) && (cmd_op <= 3'd4));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    p_mask_low_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> lock_mask == '0);

    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen && reg_addr == 2'd2 && !reg_wdata[0] && !busy |=> lock_mask == '0 && !busy);

    p_regs_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base) && $stable(size));

    p_ctrl_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd2 |-> reg_rdata[DATA_W-1:2] == '0);

endmodule

bind dlock_ctrl dlock_chk #(.ADDR_W(ADDR_W), .SET_W(SET_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_ack   (cmd_ack),
    .lock_mask (lock_mask),
    .busy      (busy_w),
    .base      (base_w),
    .size      (size_w)
);

// File: tb/tb_dlock_ctrl.sv
module tb_dlock_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_addr;
    logic        cmd_ack = 1'b0;
    logic [7:0]  lock_mask;

    int checks = 0;
    int fails  = 0;

    logic [2:0]  log_op [512];
    logic [15:0] log_ad [512];
    int nlog, hold_bad, mask_bad;

    always #10 clk = ~clk;

    dlock_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_ack(cmd_ack), .lock_mask(lock_mask)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // answers commands until the walk ends; dly = idle cycles before each ack
    task automatic serve(input int dly);
        int waited = 0;
        int guard = 0;
        bit holding = 0;
        logic [2:0]  hop = '0;
        logic [15:0] had = '0;
        nlog = 0; hold_bad = 0; mask_bad = 0;
        reg_addr = 2'd2;
        forever begin
            @(negedge clk);
            cmd_ack = 1'b0;
            #1;
            guard++;
            if (guard > 20000) break;
            if (reg_rdata[1] && lock_mask != 8'h00) mask_bad++;
            if (!reg_rdata[1] && !cmd_valid) break;
            if (cmd_valid) begin
                if (holding && (cmd_op != hop || cmd_addr != had)) hold_bad++;
                if (waited < dly) begin
                    waited++; holding = 1; hop = cmd_op; had = cmd_addr;
                end else if (nlog < 512) begin
                    log_op[nlog] = cmd_op; log_ad[nlog] = cmd_addr; nlog++;
                    cmd_ack = 1'b1; waited = 0; holding = 0;
                end
            end
        end
    endtask

    function automatic logic [7:0] exp_mask(input int b, input int sz);
        logic [7:0] m = '0;
        for (int a = b; a < b + sz; a += 16) m[(a >> 4) & 7] = 1'b1;
        return m;
    endfunction

    task automatic verify_walk(input int b, input int sz, input string tag);
        int n = sz >> 4;
        int bad = 0;
        int first_bad = -1;
        chk(nlog == 4 * n, {tag, " R4 command count"}, nlog, 4 * n);
        for (int k = 0; k < nlog && k < 4 * n; k++) begin
            int eop, ead, j;
            if (k < n) begin eop = 1; ead = b + 16 * k; end
            else if (k < 3 * n) begin j = k - n; eop = (j % 2 == 0) ? 2 : 3; ead = b + 16 * (j / 2); end
            else begin eop = 4; ead = b + 16 * (k - 3 * n); end
            if (log_op[k] != 3'(eop) || log_ad[k] != 16'(ead)) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        end
        chk(bad == 0, {tag, " R3 R4 command order/addresses (first bad index)"}, first_bad, -1);
        chk(hold_bad == 0, {tag, " R5 command held until ack"}, hold_bad, 0);
        chk(mask_bad == 0, {tag, " R7 mask zero while busy"}, mask_bad, 0);
        chk(lock_mask == exp_mask(b, sz), {tag, " R6 lock mask"}, lock_mask, exp_mask(b, sz));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd2, v); chk(v == 0, "R1 control after reset", v, 0);
        chk(lock_mask == 0, "R1 mask after reset", lock_mask, 0);
        chk(cmd_valid == 0, "R1 no command after reset", cmd_valid, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_1234); rd(2'd0, v); chk(v == 32'h1230, "R2 base read-back", v, 32'h1230);
        wr(2'd1, 32'h0000_0035); rd(2'd1, v); chk(v == 32'h0030, "R2 size read-back", v, 32'h30);
        wr(2'd2, 32'hFFFF_FFFC); rd(2'd2, v); chk(v == 0, "R2 reserved control bits", v, 0);
        rd(2'd3, v); chk(v == 0, "R2 unused index", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        wr(2'd0, 32'h0100); wr(2'd1, 32'h0030);
        wr(2'd2, 32'h1);
        serve(0);
        verify_walk(32'h0100, 32'h30, "basic");
        rd(2'd2, v); chk(v == 32'h1, "R6 enable set, busy clear after walk", v, 1);
    endtask

    task automatic t_wrap_sets();
        wr(2'd0, 32'h0170); wr(2'd1, 32'h0040);
        wr(2'd2, 32'h1);
        serve(2);
        verify_walk(32'h0170, 32'h40, "wrap");
    endtask

    task automatic t_rewrite();
        wr(2'd2, 32'h1);
        serve(1);
        verify_walk(32'h0170, 32'h40, "R7 rerun");
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(2'd0, 32'h0200); wr(2'd1, 32'h0020);
        wr(2'd2, 32'h1);
        rd(2'd2, v); chk(v == 32'h3, "R9 busy reads 1 during walk", v, 3);
        wr(2'd0, 32'h0800);
        wr(2'd1, 32'h0100);
        wr(2'd2, 32'h0);
        rd(2'd0, v); chk(v == 32'h0200, "R9 base write ignored", v, 32'h200);
        rd(2'd1, v); chk(v == 32'h0020, "R9 size write ignored", v, 32'h20);
        rd(2'd2, v); chk(v[0] == 1'b1, "R9 control write ignored", v, 3);
        serve(0);
        verify_walk(32'h0200, 32'h20, "R9 walk intact");
    endtask

    task automatic t_disable();
        logic [31:0] v;
        int seen = 0;
        chk(lock_mask != 0, "R8 mask set before disable", lock_mask, 8'h03);
        wr(2'd2, 32'h0);
        chk(lock_mask == 0, "R8 mask cleared by disable", lock_mask, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            if (cmd_valid) seen++;
        end
        chk(seen == 0, "R8 no command after disable", seen, 0);
        rd(2'd2, v); chk(v == 0, "R8 enable reads 0", v, 0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int seen = 0;
        wr(2'd1, 32'h0);
        reg_addr = 2'd2;
        @(negedge clk);
        reg_wen = 1'b1; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            #1;
            if (cmd_valid || reg_rdata[1] || lock_mask != 0) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R10 zero size: no busy, command or lock", seen, 0);
        rd(2'd2, v); chk(v == 32'h1, "R10 enable reads 1", v, 1);
    endtask

    task automatic t_full();
        wr(2'd0, 32'h0000); wr(2'd1, 32'h0400);
        wr(2'd2, 32'h1);
        serve(0);
        verify_walk(0, 32'h400, "R6 full 64-block walk");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_basic();
        t_wrap_sets();
        t_rewrite();
        t_busy_ignore();
        t_disable();
        t_zero();
        t_full();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule